// File: doc/BRIEF.md
# Trap Redirect Unit

When a 64-bit core takes an exception, trap or interrupt, this block redirects execution to a handler. The core presents a 4-bit cause code with a one-cycle `trig_i` pulse. With the cause it gives an 8-bit function code, which only library calls use, and also the current program counter, the current privileged-mode bit and the base address of the privileged handler library. On the next clock edge the block produces the handler entry address, which is the base plus a per-cause offset. In the same edge it produces a saved return address whose bit 0 records the previous mode. It also raises the privileged-mode flag, pulses `redir_o` and returns the pending-cause status to idle. The core takes these values when it sees `redir_o`.

There are two kinds of entry point. Hardware causes use fixed slots spaced 128 bytes apart. Library calls use 64-byte slots, which lie in one of two regions. Bit 7 of the function code picks the region: one region holds privileged calls and the other holds unprivileged calls. Store-conditional causes and unassigned codes have no entry point. For these the block pulses `err_o` and leaves the redirect outputs untouched.

Top module: `trap_redirect`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads `new_pc_o` with `base_i`, `exc_addr_o` with 0, `priv_o` with 1 and `pend_o` with 15, and clears `redir_o` and `err_o`.
- R2: Cause codes 0 to 9 each have a fixed slot. The codes are reset 0, machine check 1, inter-processor 2, clock 3, device 4, translation fault 5, misaligned access 6, bad opcode 7, arithmetic 8 and FP disabled 9. When `trig_i` is high with one of these codes, `new_pc_o` becomes `base_i + code*0x80` one cycle later.
- R3: Cause code 10 is a library call. If `func_i[7]` is 0, `new_pc_o` becomes `base_i + 0x1000 + func_i[6:0]*64`.
- R4: For cause 10 with `func_i[7]` equal to 1, `new_pc_o` becomes `base_i + 0x2000 + (func_i - 0x80)*64`. The addition is a full 64-bit add.
- R5: On any dispatch (causes 0 to 10), `exc_addr_o` becomes `pc_i` with bit 0 ORed with `priv_i`.
- R6: On any dispatch, `priv_o` is 1 and `redir_o` is high for exactly the one cycle after the `trig_i` edge.
- R7: On any dispatch, `pend_o` returns to the idle code 15.
- R8: Causes 11 and 12 (the two store-conditional causes) and the unassigned causes 13 and 14 pulse `err_o` for one cycle and set `pend_o` to the offending code. They leave `new_pc_o`, `exc_addr_o` and `priv_o` unchanged. `redir_o` and `err_o` are never high together.
- R9: `trig_i` with cause 15 (idle) has no effect on any output.
- R10: With `trig_i` low, all outputs hold their values and `redir_o` and `err_o` stay low, whatever the other inputs do.
- R11: If `rst` and `trig_i` are high in the same cycle, reset wins and the outputs take the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Take the presented cause this cycle |
| cause_i | input | 4 | Cause code |
| func_i | input | 8 | Library-call function code |
| pc_i | input | 64 | Program counter at the trap |
| priv_i | input | 1 | Current privileged-mode bit |
| base_i | input | 64 | Handler library base, 8 KB aligned |
| new_pc_o | output | 64 | Handler entry address |
| exc_addr_o | output | 64 | Saved return address, bit 0 = previous mode |
| priv_o | output | 1 | Mode to adopt after the redirect |
| pend_o | output | 4 | Pending-cause status, 15 = idle |
| redir_o | output | 1 | One-cycle redirect strobe |
| err_o | output | 1 | One-cycle undispatchable-cause strobe |

## Verification
Reset and dispatch are the two functions that can land in the same cycle. The bench drives `trig_i` with a valid cause while `rst` is still high and uses a base value that differs from the one in the previous reset. It expects the reset values computed from that new base, with no redirect strobe. A following dispatch uses a base with bit 13 set, so the expected entry address shows a carry between the region offset and the base. A bitwise merge would get this address wrong.

// File: rtl/trap_vec_pkg.sv
`timescale 1ns/1ps
package trap_vec_pkg;
   localparam int CAUSE_W = 4;

   typedef enum logic [1:0] {
      KIND_FIXED = 2'd0,
      KIND_LIB   = 2'd1,
      KIND_IDLE  = 2'd2,
      KIND_BAD   = 2'd3
   } kind_e;
endpackage

// File: rtl/trap_cause_decode.sv
`timescale 1ns/1ps
module trap_cause_decode
   import trap_vec_pkg::*;
#(
   parameter int NUM_FIXED = 10,
   parameter int LIB_CODE  = 10,
   parameter int IDLE_CODE = 15
) (
   input  logic [CAUSE_W-1:0] cause_i,
   output kind_e              kind_o
);
   localparam logic [CAUSE_W-1:0] FIXED_LIM = CAUSE_W'(NUM_FIXED);
   localparam logic [CAUSE_W-1:0] LIB_C     = CAUSE_W'(LIB_CODE);
   localparam logic [CAUSE_W-1:0] IDLE_C    = CAUSE_W'(IDLE_CODE);

   always_comb begin
      if (cause_i < FIXED_LIM)    kind_o = KIND_FIXED;
      else if (cause_i == LIB_C)  kind_o = KIND_LIB;
      else if (cause_i == IDLE_C) kind_o = KIND_IDLE;
      else                        kind_o = KIND_BAD;
   end
endmodule

// File: rtl/trap_offset_gen.sv
`timescale 1ns/1ps
module trap_offset_gen
   import trap_vec_pkg::*;
#(
   parameter int FUNC_W      = 8,
   parameter int VEC_SHIFT   = 7,
   parameter int SLOT_SHIFT  = 6,
   parameter int PRIV_REGION = 'h1000,
   parameter int USER_REGION = 'h2000,
   parameter int OFS_W       = 14
) (
   input  kind_e              kind_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [FUNC_W-1:0]  func_i,
   output logic [OFS_W-1:0]   ofs_o
);
   logic [OFS_W-1:0] fixed_ofs;
   logic [OFS_W-1:0] slot_ofs;
   logic [OFS_W-1:0] region;

   always_comb begin
      fixed_ofs = OFS_W'(cause_i) << VEC_SHIFT;
      slot_ofs  = OFS_W'(func_i[FUNC_W-2:0]) << SLOT_SHIFT;
      region    = func_i[FUNC_W-1] ? OFS_W'(USER_REGION) : OFS_W'(PRIV_REGION);
      unique case (kind_i)
         KIND_FIXED: ofs_o = fixed_ofs;
         KIND_LIB:   ofs_o = region + slot_ofs;
         default:    ofs_o = '0;
      endcase
   end
endmodule

// File: rtl/trap_target_merge.sv
`timescale 1ns/1ps
module trap_target_merge #(
   parameter int XLEN     = 64,
   parameter int OFS_W    = 14,
   parameter bit MERGE_OR = 1'b0
) (
   input  logic [XLEN-1:0]  base_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic [XLEN-1:0]  target_o
);
   generate
      if (MERGE_OR) begin : g_or
         assign target_o = {base_i[XLEN-1:OFS_W], base_i[OFS_W-1:0] | ofs_i};
      end else begin : g_add
         assign target_o = base_i + {{(XLEN-OFS_W){1'b0}}, ofs_i};
      end
   endgenerate
endmodule

// File: rtl/trap_redirect.sv
`timescale 1ns/1ps
module trap_redirect
   import trap_vec_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int FUNC_W      = 8,
   parameter int NUM_FIXED   = 10,
   parameter int LIB_CODE    = 10,
   parameter int VEC_SHIFT   = 7,
   parameter int SLOT_SHIFT  = 6,
   parameter int PRIV_REGION = 'h1000,
   parameter int USER_REGION = 'h2000,
   parameter bit MERGE_OR    = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               trig_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [FUNC_W-1:0]  func_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic               priv_i,
   input  logic [XLEN-1:0]    base_i,
   output logic [XLEN-1:0]    new_pc_o,
   output logic [XLEN-1:0]    exc_addr_o,
   output logic               priv_o,
   output logic [CAUSE_W-1:0] pend_o,
   output logic               redir_o,
   output logic               err_o
);
   localparam int IDLE_CODE = (1 << CAUSE_W) - 1;
   localparam int LIB_SPAN  = (1 << (FUNC_W - 1)) << SLOT_SHIFT;
   localparam int OFS_W     = $clog2(USER_REGION + LIB_SPAN);
   localparam logic [CAUSE_W-1:0] IDLE_C = CAUSE_W'(IDLE_CODE);

   generate
      if (XLEN <= OFS_W) begin : g_chk_xlen
         $error("XLEN must exceed the offset width");
      end
      if ((NUM_FIXED << VEC_SHIFT) > PRIV_REGION) begin : g_chk_fixed
         $error("fixed slots overlap the library region");
      end
      if (LIB_CODE < NUM_FIXED || LIB_CODE >= IDLE_CODE) begin : g_chk_lib
         $error("library cause code out of range");
      end
      if (FUNC_W < 2) begin : g_chk_func
         $error("function code too narrow");
      end
   endgenerate

   kind_e            kind;
   logic [OFS_W-1:0] ofs;
   logic [XLEN-1:0]  target;

   trap_cause_decode #(
      .NUM_FIXED (NUM_FIXED),
      .LIB_CODE  (LIB_CODE),
      .IDLE_CODE (IDLE_CODE)
   ) u_decode (
      .cause_i (cause_i),
      .kind_o  (kind)
   );

   trap_offset_gen #(
      .FUNC_W      (FUNC_W),
      .VEC_SHIFT   (VEC_SHIFT),
      .SLOT_SHIFT  (SLOT_SHIFT),
      .PRIV_REGION (PRIV_REGION),
      .USER_REGION (USER_REGION),
      .OFS_W       (OFS_W)
   ) u_offset (
      .kind_i  (kind),
      .cause_i (cause_i),
      .func_i  (func_i),
      .ofs_o   (ofs)
   );

   trap_target_merge #(
      .XLEN     (XLEN),
      .OFS_W    (OFS_W),
      .MERGE_OR (MERGE_OR)
   ) u_merge (
      .base_i   (base_i),
      .ofs_i    (ofs),
      .target_o (target)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         new_pc_o   <= base_i;
         exc_addr_o <= '0;
         priv_o     <= 1'b1;
         pend_o     <= IDLE_C;
         redir_o    <= 1'b0;
         err_o      <= 1'b0;
      end else begin
         redir_o <= 1'b0;
         err_o   <= 1'b0;
         if (trig_i) begin
            unique case (kind)
               KIND_FIXED, KIND_LIB: begin
                  new_pc_o   <= target;
                  exc_addr_o <= {pc_i[XLEN-1:1], pc_i[0] | priv_i};
                  priv_o     <= 1'b1;
                  pend_o     <= IDLE_C;
                  redir_o    <= 1'b1;
               end
               KIND_BAD: begin
                  pend_o <= cause_i;
                  err_o  <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assert_redir_priv_R6: assert property (@(posedge clk) disable iff (rst)
      redir_o |-> priv_o);

   assert_redir_pend_idle_R7: assert property (@(posedge clk) disable iff (rst)
      redir_o |-> pend_o == IDLE_C);

   assert_save_mode_bit_R5: assert property (@(posedge clk) disable iff (rst)
      redir_o |-> exc_addr_o[0] == ($past(pc_i[0]) | $past(priv_i)));

   assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
      !(redir_o && err_o));

   assert_err_no_redirect_R8: assert property (@(posedge clk) disable iff (rst)
      err_o |-> $stable(new_pc_o) && $stable(exc_addr_o) && pend_o != IDLE_C);

   assert_idle_ignored_R9: assert property (@(posedge clk) disable iff (rst)
      trig_i && cause_i == IDLE_C |=> !redir_o && !err_o);

   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(trig_i) |-> $stable(new_pc_o) && $stable(exc_addr_o)
                                       && $stable(pend_o) && !redir_o && !err_o);

   generate
      if (MERGE_OR) begin : g_align_chk
         assert_base_aligned_R4: assert property (@(posedge clk) disable iff (rst)
            trig_i |-> base_i[OFS_W-1:0] == '0);
      end
   endgenerate
endmodule

// File: tb/trap_redirect_bench.sv
`timescale 1ns/1ps
module trap_redirect_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        trig_i;
   logic [3:0]  cause_i;
   logic [7:0]  func_i;
   logic [63:0] pc_i;
   logic        priv_i;
   logic [63:0] base_i;
   logic [63:0] new_pc_o;
   logic [63:0] exc_addr_o;
   logic        priv_o;
   logic [3:0]  pend_o;
   logic        redir_o;
   logic        err_o;

   always #2 clk = ~clk;

   trap_redirect u_trap_redirect (
      .clk        (clk),
      .rst        (rst),
      .trig_i     (trig_i),
      .cause_i    (cause_i),
      .func_i     (func_i),
      .pc_i       (pc_i),
      .priv_i     (priv_i),
      .base_i     (base_i),
      .new_pc_o   (new_pc_o),
      .exc_addr_o (exc_addr_o),
      .priv_o     (priv_o),
      .pend_o     (pend_o),
      .redir_o    (redir_o),
      .err_o      (err_o)
   );

   typedef struct {
      logic [63:0] pc;
      logic [63:0] ea;
      logic        priv;
      logic [3:0]  pend;
      logic        redir;
      logic        err;
      string       tag;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [63:0] m_pc = '0;
   logic [63:0] m_ea = '0;
   logic        m_priv = 1'b1;
   logic [3:0]  m_pend = 4'd15;

   task automatic step(input logic r, input logic t, input logic [3:0] c,
                       input logic [7:0] f, input logic [63:0] p, input logic pv,
                       input logic [63:0] b, input string tag);
      exp_t e;
      logic [63:0] ofs;
      @(negedge clk);
      rst = r; trig_i = t; cause_i = c; func_i = f; pc_i = p; priv_i = pv; base_i = b;
      e.redir = 1'b0;
      e.err   = 1'b0;
      if (r) begin
         m_pc = b; m_ea = '0; m_priv = 1'b1; m_pend = 4'd15;
      end else if (t) begin
         if (c <= 4'd10) begin
            if (c == 4'd10)
               ofs = (f[7] ? 64'h2000 : 64'h1000) + 64'(f[6:0]) * 64;
            else
               ofs = 64'(c) * 64'h80;
            m_pc = b + ofs; m_ea = p | 64'(pv); m_priv = 1'b1; m_pend = 4'd15;
            e.redir = 1'b1;
         end else if (c != 4'd15) begin
            m_pend = c;
            e.err  = 1'b1;
         end
      end
      e.pc = m_pc; e.ea = m_ea; e.priv = m_priv; e.pend = m_pend; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (new_pc_o !== e.pc || exc_addr_o !== e.ea || priv_o !== e.priv ||
                pend_o !== e.pend || redir_o !== e.redir || err_o !== e.err) begin
               bad++;
               $display("FAIL %s: got pc=%h ea=%h priv=%b pend=%0d redir=%b err=%b exp pc=%h ea=%h priv=%b pend=%0d redir=%b err=%b",
                        e.tag, new_pc_o, exc_addr_o, priv_o, pend_o, redir_o, err_o,
                        e.pc, e.ea, e.priv, e.pend, e.redir, e.err);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] b0;
      logic [63:0] b1;
      b0 = 64'h0000_1234_5678_0000;
      b1 = 64'hFFFF_0000_0000_2000;
      rst = 1'b1; trig_i = 1'b0; cause_i = 4'd15; func_i = '0;
      pc_i = '0; priv_i = 1'b0; base_i = b0;
      step(1, 0, 4'd15, 8'h00, 64'h0, 0, b0, "R1 reset");
      step(1, 0, 4'd15, 8'h00, 64'h0, 0, b0, "R1 reset");
      for (int c = 0; c < 10; c++)
         step(0, 1, 4'(c), 8'hA5, 64'h0000_0000_0040_1000 + 64'(c * 8), c[0], b0,
              "R2 R5 R6 R7 fixed slot");
      step(0, 1, 4'd10, 8'h00, 64'h0000_0000_0070_0004, 0, b0, "R3 lib call 0x00");
      step(0, 1, 4'd10, 8'h3F, 64'h0000_0000_0070_0008, 1, b0, "R3 lib call 0x3F");
      step(0, 1, 4'd10, 8'h80, 64'h0000_0000_0070_000C, 0, b0, "R4 lib call 0x80");
      step(0, 1, 4'd10, 8'hBF, 64'h0000_0000_0070_0011, 0, b0, "R4 R5 lib call 0xBF");
      step(0, 1, 4'd10, 8'h7F, 64'h0000_0000_0070_0010, 1, b0, "R3 lib call 0x7F");
      for (int c = 11; c < 15; c++)
         step(0, 1, 4'(c), 8'h12, 64'hDEAD_0000_0000_0000, 0, b1, "R8 no slot");
      step(0, 0, 4'd3, 8'h44, 64'h1111_2222_3333_4444, 1, b1, "R10 idle hold");
      step(0, 0, 4'd10, 8'hFF, 64'h5555, 0, b0, "R10 idle hold");
      step(0, 1, 4'd1, 8'h00, 64'h0000_0000_0000_8000, 1, b0, "R5 R7 recover after error");
      step(0, 1, 4'd15, 8'h80, 64'h9999, 0, b1, "R9 idle cause");
      step(0, 1, 4'd15, 8'h00, 64'h7777, 1, b0, "R9 idle cause");
      step(1, 1, 4'd4, 8'h00, 64'h1234, 0, b1, "R11 reset beats trig");
      step(0, 1, 4'd10, 8'hBF, 64'h0000_0000_0000_2000, 1, b1, "R4 carry into base");
      step(0, 1, 4'd9, 8'h00, 64'h0000_0000_0000_3000, 0, b1, "R2 last fixed slot");
      step(0, 0, 4'd0, 8'h00, 64'h0, 0, b1, "R6 strobe drops");
      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule